// File: doc/BRIEF.md
# Region-Based Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address for a machine with 512-byte pages and three address regions, each described by one flat page table. The two per-process regions keep their tables in shared system virtual space. A per-process lookup therefore starts with a system-table lookup that locates the page holding the entry it needs, and only then fetches that entry.

A requester presents `req_va` with `req_valid` while `req_ready` is high. The block then reads page-table entries, one at a time, through a simple read port and returns a single-cycle response: either the physical address or a fault code. The base and length of each region's table are plain inputs held stable by the surrounding logic.

Fault codes on `resp_fault`: 0 = success, 1 = reserved address, 2 = length violation, 3 = entry not valid. A page-table entry is 32 bits. Bit 31 is its valid flag and bits 20:0 are its frame number.

Top module: `vaddr_xlate`

## Requirements
- R1: VA[31:30] selects the region: 00 lower process region, 01 upper process region, 10 system region. The value 11 gives fault code 1 in the cycle right after acceptance, without any memory read.
- R2: Physical address = {PTE[20:0], VA[8:0]}. The 9-bit page offset passes through unchanged, and PTE bits 30:21 have no effect.
- R3: A system address reads its entry at physical `sys_base + 4*VA[29:9]`, wrapping modulo 2^30. A page number at or above `sys_len` gives fault code 2 with no memory read.
- R4: A lower process address whose page number VA[29:9] is at or above `p0_len` gives fault code 2 with no memory read.
- R5: An upper process address whose page number is below `p1_len` gives fault code 2 with no memory read. Numbers at or above it are mapped, which lets the region's table grow downward.
- R6: For a process address, the entry's virtual address is `base + 4*VA[29:9]`, wrapping modulo 2^32. Its system entry is read at `sys_base + 4*E[29:9]`. The process entry is then read at {system PTE[20:0], E[8:0]}.
- R7: If that entry address E does not have bits 31:30 = 10, the result is fault code 1. If its page number is at or above `sys_len`, the result is fault code 2. Neither case reads memory.
- R8: An entry with bit 31 clear, at either level, ends the lookup with fault code 3 and no further read.
- R9: Each accepted request yields exactly one response, and `resp_valid` is high for one cycle. `req_ready` is low from acceptance through the response cycle, and `req_valid` has no effect while it is low. After reset, `req_ready`=1, `resp_valid`=0 and `mem_rd_req`=0.
- R10: `mem_rd_req` stays high with a stable `mem_rd_addr` until `mem_rd_ack`. Data is taken in the ack cycle, and no read is pending while a response is given.
- R11: A faulting response carries `resp_pa` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_va | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block idle, request accepted |
| sys_base | input | 30 | Physical base of the system table |
| sys_len | input | 22 | System table length in entries |
| p0_base | input | 32 | System virtual base of the lower process table |
| p0_len | input | 22 | Lower process table length |
| p1_base | input | 32 | System virtual base of the upper process table |
| p1_len | input | 22 | First mapped page of the upper process region |
| mem_rd_req | output | 1 | Entry read pending |
| mem_rd_addr | output | 30 | Physical byte address of the entry |
| mem_rd_ack | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Entry read from memory |
| resp_valid | output | 1 | Response strobe |
| resp_pa | output | 30 | Physical address, zero on fault |
| resp_fault | output | 2 | 0 ok, 1 reserved, 2 length, 3 not valid |

## Verification
The bench aims at the edges of each length check: the last mapped and first unmapped page of the lower and system regions, and the exact boundary of the upward-mapped upper region. A design with an inverted or off-by-one comparison would map one page too many, or fault on a valid one.

It also checks the nested walk's addresses and read counts. A translator that skipped the system step would fetch from a virtual address, and one that ignored a bad system entry would still issue a second read; either error shows up as a wrong address or a wrong count.

Further cases cover:
- wraparound of the system table base;
- a full-width frame number with junk in the reserved entry bits;
- a held `req_valid` during a busy walk, where a double response or a second acceptance would appear at the ports.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  parameter int PTE_W = 32,
  localparam int VPN_W = VA_W - 2 - OFF_W,
  localparam int LEN_W = VPN_W + 1,
  localparam int PFN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_va,
  output logic             req_ready,
  input  logic [PA_W-1:0]  sys_base,
  input  logic [LEN_W-1:0] sys_len,
  input  logic [VA_W-1:0]  p0_base,
  input  logic [LEN_W-1:0] p0_len,
  input  logic [VA_W-1:0]  p1_base,
  input  logic [LEN_W-1:0] p1_len,
  output logic             mem_rd_req,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_ack,
  input  logic [PTE_W-1:0] mem_rd_data,
  output logic             resp_valid,
  output logic [PA_W-1:0]  resp_pa,
  output logic [1:0]       resp_fault
);

  localparam logic [1:0] RG_P0 = 2'b00, RG_P1 = 2'b01, RG_SYS = 2'b10;
  localparam logic [1:0] F_OK = 2'd0, F_RSV = 2'd1, F_LEN = 2'd2, F_INV = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_SYS, S_USR, S_RESP} st_t;

  st_t              st;
  logic             nested_q;
  logic [OFF_W-1:0] off_q, pte_off_q;
  logic [PA_W-1:0]  addr_q, pa_q;
  logic [1:0]       fault_q;

  wire [1:0]       rgn    = req_va[VA_W-1 -: 2];
  wire [VPN_W-1:0] vpn    = req_va[VA_W-3:OFF_W];
  wire [LEN_W-1:0] vpn_x  = {1'b0, vpn};
  wire [VA_W-1:0]  ubase  = rgn[0] ? p1_base : p0_base;
  wire [VA_W-1:0]  pte_va = ubase + VA_W'({vpn, 2'b00});
  wire             is_sys = (rgn == RG_SYS);
  wire [VA_W-1:0]  sva    = is_sys ? req_va : pte_va;
  wire [VPN_W-1:0] svpn   = sva[VA_W-3:OFF_W];
  wire [PA_W-1:0]  s_addr = sys_base + PA_W'({svpn, 2'b00});

  wire len_bad = (rgn == RG_P0  && vpn_x >= p0_len) ||
                 (rgn == RG_P1  && vpn_x <  p1_len) ||
                 (is_sys        && vpn_x >= sys_len);
  wire nest_rsv = !is_sys && (sva[VA_W-1 -: 2] != RG_SYS);
  wire nest_len = !is_sys && ({1'b0, svpn} >= sys_len);

  wire             pte_ok  = mem_rd_data[PTE_W-1];
  wire [PFN_W-1:0] pte_pfn = mem_rd_data[PFN_W-1:0];
  logic unused_pte_bits;
  assign unused_pte_bits = ^mem_rd_data[PTE_W-2:PFN_W];

  assign req_ready   = (st == S_IDLE);
  assign mem_rd_req  = (st == S_SYS) || (st == S_USR);
  assign mem_rd_addr = addr_q;
  assign resp_valid  = (st == S_RESP);
  assign resp_pa     = pa_q;
  assign resp_fault  = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      nested_q  <= 1'b0;
      off_q     <= '0;
      pte_off_q <= '0;
      addr_q    <= '0;
      pa_q      <= '0;
      fault_q   <= F_OK;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          off_q     <= req_va[OFF_W-1:0];
          pte_off_q <= sva[OFF_W-1:0];
          nested_q  <= !is_sys;
          pa_q      <= '0;
          fault_q   <= F_OK;
          if (rgn == 2'b11) begin
            fault_q <= F_RSV;
            st      <= S_RESP;
          end else if (len_bad) begin
            fault_q <= F_LEN;
            st      <= S_RESP;
          end else if (nest_rsv) begin
            fault_q <= F_RSV;
            st      <= S_RESP;
          end else if (nest_len) begin
            fault_q <= F_LEN;
            st      <= S_RESP;
          end else begin
            addr_q <= s_addr;
            st     <= S_SYS;
          end
        end
        S_SYS: if (mem_rd_ack) begin
          if (!pte_ok) begin
            fault_q <= F_INV;
            st      <= S_RESP;
          end else if (nested_q) begin
            addr_q <= {pte_pfn, pte_off_q};
            st     <= S_USR;
          end else begin
            pa_q <= {pte_pfn, off_q};
            st   <= S_RESP;
          end
        end
        S_USR: if (mem_rd_ack) begin
          if (!pte_ok) fault_q <= F_INV;
          else         pa_q    <= {pte_pfn, off_q};
          st <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vaddr_xlate_chk.sv
module vaddr_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 30,
  parameter int OFF_W = 9,
  localparam int VPN_W = VA_W - 2 - OFF_W,
  localparam int LEN_W = VPN_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [VA_W-1:0]  req_va,
  input logic [LEN_W-1:0] p0_len,
  input logic             mem_rd_req,
  input logic [PA_W-1:0]  mem_rd_addr,
  input logic             mem_rd_ack,
  input logic             resp_valid,
  input logic [PA_W-1:0]  resp_pa,
  input logic [1:0]       resp_fault
);

  wire acc = req_valid && req_ready;
  logic [OFF_W-1:0] cap_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_off <= '0;
    else if (acc) cap_off <= req_va[OFF_W-1:0];
  end

  AST_RSV_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_va[VA_W-1 -: 2] == 2'b11 |=> resp_valid && resp_fault == 2'd1); // R1
  AST_RSV_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_va[VA_W-1 -: 2] == 2'b11 |=> !mem_rd_req); // R1
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == 2'd0 |-> resp_pa[OFF_W-1:0] == cap_off); // R2
  AST_P0_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_va[VA_W-1 -: 2] == 2'b00 && {1'b0, req_va[VA_W-3:OFF_W]} >= p0_len
    |=> resp_valid && resp_fault == 2'd2); // R4
  AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr)); // R10
  AST_NO_READ_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !mem_rd_req); // R10
  AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault != 2'd0 |-> resp_pa == '0); // R11

endmodule

bind vaddr_xlate vaddr_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_va(req_va), .p0_len(p0_len), .mem_rd_req(mem_rd_req),
  .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack), .resp_valid(resp_valid),
  .resp_pa(resp_pa), .resp_fault(resp_fault)
);

// File: tb/vaddr_xlate_bench.sv
`timescale 1ns/1ps
module vaddr_xlate_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0;
  logic [31:0] req_va = '0;
  logic        req_ready;
  logic [29:0] sys_base;
  logic [21:0] sys_len, p0_len, p1_len;
  logic [31:0] p0_base, p1_base;
  logic        mem_rd_req;
  logic [29:0] mem_rd_addr;
  logic        mem_rd_ack;
  logic [31:0] mem_rd_data;
  logic        resp_valid;
  logic [29:0] resp_pa;
  logic [1:0]  resp_fault;

  int checks = 0, errors = 0;
  int rd_count = 0, stab_err = 0, mem_dly = 0;
  logic [29:0] hist [4];

  always #4 clk = ~clk;

  vaddr_xlate u_vaddr_xlate (.*);

  function automatic logic [31:0] mem_lookup(input logic [29:0] a);
    case (a)
      30'h0000_0000: return 32'h8000_0011;
      30'h0010_0000: return 32'h8000_0123;
      30'h0010_0004: return 32'h8000_0040;
      30'h0010_0008: return 32'h0000_0077;
      30'h0010_000C: return 32'h8000_0060;
      30'h0010_0010: return 32'hFFFF_FFFF;
      30'h0000_8000: return 32'h8000_0005;
      30'h0000_8004: return 32'h0000_0009;
      30'h0000_803C: return 32'h8000_0ABC;
      30'h0000_C000: return 32'h8000_0001;
      30'h0000_C03C: return 32'h8000_0777;
      default:       return 32'h0;
    endcase
  endfunction

  // memory responder: ack after mem_dly waiting cycles, one ack per read
  initial begin
    int cnt = 0;
    logic waiting = 0;
    logic [29:0] prev = '0;
    mem_rd_ack = 0; mem_rd_data = '0;
    forever begin
      @(negedge clk);
      if (mem_rd_ack) mem_rd_ack = 0;
      else if (mem_rd_req) begin
        if (waiting && mem_rd_addr != prev) stab_err++;
        prev = mem_rd_addr; waiting = 1;
        if (cnt >= mem_dly) begin
          mem_rd_ack = 1; mem_rd_data = mem_lookup(mem_rd_addr);
          hist[rd_count & 3] = mem_rd_addr;
          rd_count++; cnt = 0; waiting = 0;
        end else cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] va, output logic [1:0] f, output logic [29:0] pa,
                     output int reads, output int pulses);
    int r0 = rd_count;
    int guard = 0;
    @(negedge clk); req_valid = 1; req_va = va;
    @(negedge clk); req_valid = 0;
    while (!resp_valid && guard < 200) begin @(negedge clk); guard++; end
    f = resp_fault; pa = resp_pa; pulses = resp_valid ? 1 : 0;
    @(negedge clk); if (resp_valid) pulses++;
    reads = rd_count - r0;
  endtask

  // {va, fault, reads, pa}
  localparam logic [65:0] VEC [15] = '{
    {32'h8000_0123, 2'd0, 2'd1, 30'h0002_4723},
    {32'h8000_0400, 2'd3, 2'd1, 30'h0},
    {32'h8000_08AB, 2'd0, 2'd1, 30'h3FFF_FEAB},
    {32'h8001_FE00, 2'd3, 2'd1, 30'h0},
    {32'h8002_0000, 2'd2, 2'd0, 30'h0},
    {32'h0000_0010, 2'd0, 2'd2, 30'h0000_0A10},
    {32'h0000_0200, 2'd3, 2'd2, 30'h0},
    {32'h0000_1FFF, 2'd0, 2'd2, 30'h0015_79FF},
    {32'h0000_2000, 2'd2, 2'd0, 30'h0},
    {32'h7FFF_FFFF, 2'd0, 2'd2, 30'h000E_EFFF},
    {32'h7FFF_E00C, 2'd0, 2'd2, 30'h0000_020C},
    {32'h7FFF_DFFF, 2'd2, 2'd0, 30'h0},
    {32'hC000_0000, 2'd1, 2'd0, 30'h0},
    {32'hFFFF_FFFF, 2'd1, 2'd0, 30'h0},
    {32'h0000_0400, 2'd3, 2'd2, 30'h0}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 4:          return "R3";
      2:             return "R2";
      1, 3, 6, 14:   return "R8";
      5:             return "R6";
      7, 8:          return "R4";
      9, 10, 11:     return "R5";
      default:       return "R1";
    endcase
  endfunction

  initial begin
    int watch = 0;
    while (watch < 100000) begin @(posedge clk); watch++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", watch, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] f; logic [29:0] pa; int rd, pl, r0;
    sys_base = 30'h0010_0000; sys_len = 22'h100;
    p0_base = 32'h8000_0200;  p0_len = 22'h10;
    p1_base = 32'h7F80_0640;  p1_len = 22'h1F_FFF0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(req_ready == 1 && resp_valid == 0 && mem_rd_req == 0, "R9 reset",
        {req_ready, resp_valid, mem_rd_req}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 15; i++) begin
      mem_dly = i % 3;
      run(VEC[i][65:34], f, pa, rd, pl);
      chk(f == VEC[i][33:32], {vtag(i), " fault"}, f, VEC[i][33:32]);
      chk(pa == VEC[i][29:0], {vtag(i), " pa"}, pa, VEC[i][29:0]);
      chk(rd == int'(VEC[i][31:30]), {vtag(i), " reads"}, rd, VEC[i][31:30]);
      chk(pl == 1, "R9 single response", pl, 1);
      if (VEC[i][33:32] != 0) chk(pa == 0, "R11 fault pa", pa, 0);
    end

    // R6 nested walk addresses for the top upper-region page
    r0 = rd_count;
    run(32'h7FFF_FFFF, f, pa, rd, pl);
    chk(hist[r0 & 3] == 30'h0010_000C, "R6 system read addr", hist[r0 & 3], 30'h0010_000C);
    chk(hist[(r0 + 1) & 3] == 30'h0000_C03C, "R6 process read addr", hist[(r0 + 1) & 3], 30'h0000_C03C);

    // R7 entry address outside system region / beyond system length
    p0_base = 32'h0000_1000;
    run(32'h0, f, pa, rd, pl);
    chk(f == 2'd1 && rd == 0, "R7 entry not in system space", {f, rd[3:0]}, {2'd1, 4'd0});
    p0_base = 32'h8002_0000;
    run(32'h0, f, pa, rd, pl);
    chk(f == 2'd2 && rd == 0, "R7 entry beyond system length", {f, rd[3:0]}, {2'd2, 4'd0});
    // R8 invalid system entry during nested walk stops after one read
    p0_base = 32'h8000_0400;
    run(32'h0, f, pa, rd, pl);
    chk(f == 2'd3 && rd == 1, "R8 nested system entry invalid", {f, rd[3:0]}, {2'd3, 4'd1});
    p0_base = 32'h8000_0200;

    // R3 base wraparound modulo 2^30
    sys_base = 30'h3FFF_FFFC;
    run(32'h8000_0200, f, pa, rd, pl);
    chk(f == 0 && pa == 30'h2200, "R3 base wrap", pa, 30'h2200);
    sys_base = 30'h0010_0000;

    // R9 request held during a busy walk is not accepted again
    mem_dly = 2;
    @(negedge clk); req_valid = 1; req_va = 32'h0000_0010;
    @(negedge clk); req_va = 32'hC000_0000;
    begin
      int g = 0;
      while (!resp_valid && g < 200) begin @(negedge clk); g++; end
    end
    f = resp_fault; pa = resp_pa; req_valid = 0;
    chk(f == 0 && pa == 30'hA10, "R9 busy input ignored", pa, 30'hA10);
    pl = 0;
    repeat (4) begin @(negedge clk); if (resp_valid) pl++; end
    chk(pl == 0, "R9 no extra response", pl, 0);
    chk(req_ready == 1, "R9 idle after response", req_ready, 1);

    chk(stab_err == 0, "R10 address stable while pending", stab_err, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule